// File: doc/BRIEF.md
# CAN Controller Interrupt Request Aggregator

This block sits between one CAN controller and the system interrupt controller. It takes single-cycle event pulses from the controller and records each one in a sticky status bit. There is one transmit-done event and one receive-done event for each of 16 message slots, plus three error events: bus error, entry to error-passive and entry to bus-off. Each status bit has its own enable mask. The enabled status bits are reduced to three request lines. Each line emits a one-cycle pulse when its enabled aggregate rises from zero. A downstream edge-sensitive latch captures that pulse.

A control bit picks one of two routings. In the merged routing, all enabled sources drive all three lines together. In the split routing, the lines carry transmit-done, receive-done and the error group separately. Software clears status by writing ones. While any enabled status bit of a line is still set, later events on that line produce no new pulse. A separate sticky flag records a falling edge on an asynchronous wake-up pin. The pin passes through a synchronizer before the edge is detected.

Top module: `can_irq_agg`

## Requirements
- R1: After reset, all status bits, masks, the mode bit and the wake-up flag are 0. Every register word reads 0 and all request outputs are low.
- R2: A pulse on bit i of `tx_done_i` sets bit i of word 0 (transmit status). A pulse on bit i of `rx_done_i` sets bit i of word 1 (receive status). The bit stays set until software clears it.
- R3: The error events set bits of word 4: bit 0 for bus error, bit 1 for error-passive entry, bit 2 for bus-off entry. These bits are sticky in the same way.
- R4: Writing to a status word (0, 1, 4) or to the wake word (7) clears the bits written as 1 and leaves the bits written as 0. An event on a bit in the same cycle as its clear leaves the bit set.
- R5: Words 2, 3 and 5 are plain read/write masks for the transmit, receive and error status. A set status bit whose mask bit is 0 causes no request. Setting that mask bit later counts as a rise of the enabled aggregate.
- R6: A request line is high for exactly one cycle: the cycle after the clock edge at which its enabled aggregate becomes nonzero.
- R7: With word 6 bit 0 equal to 0 (merged), any enabled source pulses all three request lines together.
- R8: With word 6 bit 0 equal to 1 (split), line 0 carries transmit-done only, line 1 carries receive-done only, and line 2 carries the OR of the three error sources.
- R9: While a line's enabled aggregate stays nonzero, further events on it produce no pulse. After it returns to 0, the next event pulses again.
- R10: A falling edge on `wake_pin_i` sets the wake-up flag (`wake_req_o`, word 7 bit 0). The flag is visible at the third clock edge after the pin changes. A rising edge has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_done_i | input | 16 | Per-slot transmit-done event pulses |
| rx_done_i | input | 16 | Per-slot receive-done event pulses |
| err_bus_i | input | 1 | Bus error event pulse |
| err_passive_i | input | 1 | Error-passive entry event pulse |
| err_busoff_i | input | 1 | Bus-off entry event pulse |
| wake_pin_i | input | 1 | Asynchronous wake-up pin |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 3 | Request pulses to the interrupt controller |
| wake_req_o | output | 1 | Sticky wake-up request flag |

## Verification
The hardest case to reach is the suppression of a second request while an earlier enabled status is still pending. A related case is a clear that lands in the same cycle as a new event. The bench first parks one transmit bit as pending. It then raises another slot and clears the two bits one at a time, checking the line and the status word after each step. Finally it issues a clear and an event on the same bit in the same write cycle. A sweep covers every source in both routings. A pending status bit is also enabled late through its mask, to show that the mask itself can raise a request.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int unsigned REG_AW  = 3;
  localparam int unsigned N_CLASS = 3;
  localparam int unsigned N_ERR   = 3;
  localparam int unsigned CLS_TX  = 0;
  localparam int unsigned CLS_RX  = 1;
  localparam int unsigned CLS_ERR = 2;

  typedef enum logic [REG_AW-1:0] {
    ADDR_TX_ST = 3'd0,
    ADDR_RX_ST = 3'd1,
    ADDR_TX_MK = 3'd2,
    ADDR_RX_MK = 3'd3,
    ADDR_ER_ST = 3'd4,
    ADDR_ER_MK = 3'd5,
    ADDR_CTRL  = 3'd6,
    ADDR_WAKE  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/can_irq_sticky.sv
module can_irq_sticky #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] st_o
);
  logic [W-1:0] st_q;
  logic [W-1:0] clr_eff;

  assign clr_eff = clr_en_i ? clr_i : '0;

  // set has priority over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= (st_q & ~clr_eff) | set_i;
  end

  assign st_o = st_q;

  assert_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q & $past(set_i)) == $past(set_i));

  assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q & $past(st_q & ~clr_eff)) == $past(st_q & ~clr_eff));
endmodule

// File: rtl/can_irq_wake_edge.sv
module can_irq_wake_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[MSB-1:0], pin_i};
      last_q <= sync_q[MSB];
    end
  end

  assign fall_o = last_q & ~sync_q[MSB];

  assert_fall_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/can_irq_req_pulse.sv
module can_irq_req_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic pulse_o
);
  logic level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= 1'b0;
    else         level_q <= level_i;
  end

  assign pulse_o = level_i & ~level_q;

  assert_one_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/can_irq_agg.sv
module can_irq_agg
  import can_irq_pkg::*;
#(
  parameter int unsigned N_SLOTS     = 16,
  parameter int unsigned DW          = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SLOTS-1:0] tx_done_i,
  input  logic [N_SLOTS-1:0] rx_done_i,
  input  logic               err_bus_i,
  input  logic               err_passive_i,
  input  logic               err_busoff_i,
  input  logic               wake_pin_i,
  input  logic               reg_we_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  output logic [N_CLASS-1:0] irq_o,
  output logic               wake_req_o
);
  logic [N_SLOTS-1:0] tx_st, rx_st, tx_mk_q, rx_mk_q;
  logic [N_ERR-1:0]   er_st, er_mk_q, er_set;
  logic               mode_q, wake_fall;
  logic [N_CLASS-1:0] cls_act, level;
  logic               wr_tx_st, wr_rx_st, wr_er_st, wr_wake;
  logic               unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DW-1:N_SLOTS];

  assign wr_tx_st = reg_we_i && (reg_addr_i == ADDR_TX_ST);
  assign wr_rx_st = reg_we_i && (reg_addr_i == ADDR_RX_ST);
  assign wr_er_st = reg_we_i && (reg_addr_i == ADDR_ER_ST);
  assign wr_wake  = reg_we_i && (reg_addr_i == ADDR_WAKE);
  assign er_set   = {err_busoff_i, err_passive_i, err_bus_i};

  can_irq_sticky #(.W(N_SLOTS)) i_tx_st (
    .clk_i, .rst_ni, .set_i(tx_done_i), .clr_en_i(wr_tx_st),
    .clr_i(reg_wdata_i[N_SLOTS-1:0]), .st_o(tx_st));
  can_irq_sticky #(.W(N_SLOTS)) i_rx_st (
    .clk_i, .rst_ni, .set_i(rx_done_i), .clr_en_i(wr_rx_st),
    .clr_i(reg_wdata_i[N_SLOTS-1:0]), .st_o(rx_st));
  can_irq_sticky #(.W(N_ERR)) i_er_st (
    .clk_i, .rst_ni, .set_i(er_set), .clr_en_i(wr_er_st),
    .clr_i(reg_wdata_i[N_ERR-1:0]), .st_o(er_st));

  can_irq_wake_edge #(.SYNC_STAGES(SYNC_STAGES)) i_wake_edge (
    .clk_i, .rst_ni, .pin_i(wake_pin_i), .fall_o(wake_fall));
  can_irq_sticky #(.W(1)) i_wake_st (
    .clk_i, .rst_ni, .set_i(wake_fall), .clr_en_i(wr_wake),
    .clr_i(reg_wdata_i[0]), .st_o(wake_req_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_mk_q <= '0;
      rx_mk_q <= '0;
      er_mk_q <= '0;
      mode_q  <= 1'b0;
    end else if (reg_we_i) begin
      case (reg_addr_e'(reg_addr_i))
        ADDR_TX_MK: tx_mk_q <= reg_wdata_i[N_SLOTS-1:0];
        ADDR_RX_MK: rx_mk_q <= reg_wdata_i[N_SLOTS-1:0];
        ADDR_ER_MK: er_mk_q <= reg_wdata_i[N_ERR-1:0];
        ADDR_CTRL:  mode_q  <= reg_wdata_i[0];
        default: ;
      endcase
    end
  end

  assign cls_act[CLS_TX]  = |(tx_st & tx_mk_q);
  assign cls_act[CLS_RX]  = |(rx_st & rx_mk_q);
  assign cls_act[CLS_ERR] = |(er_st & er_mk_q);
  assign level = mode_q ? cls_act : {N_CLASS{|cls_act}};

  for (genvar k = 0; k < N_CLASS; k++) begin : g_req
    can_irq_req_pulse i_pulse (
      .clk_i, .rst_ni, .level_i(level[k]), .pulse_o(irq_o[k]));
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_e'(reg_addr_i))
      ADDR_TX_ST: reg_rdata_o[N_SLOTS-1:0] = tx_st;
      ADDR_RX_ST: reg_rdata_o[N_SLOTS-1:0] = rx_st;
      ADDR_TX_MK: reg_rdata_o[N_SLOTS-1:0] = tx_mk_q;
      ADDR_RX_MK: reg_rdata_o[N_SLOTS-1:0] = rx_mk_q;
      ADDR_ER_ST: reg_rdata_o[N_ERR-1:0]   = er_st;
      ADDR_ER_MK: reg_rdata_o[N_ERR-1:0]   = er_mk_q;
      ADDR_CTRL:  reg_rdata_o[0]           = mode_q;
      ADDR_WAKE:  reg_rdata_o[0]           = wake_req_o;
      default: ;
    endcase
  end

  assert_merged_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && !$past(mode_q)) |-> (irq_o == {N_CLASS{irq_o[0]}}));

  assert_split_tx_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && $past(mode_q) && irq_o[CLS_TX]) |-> |(tx_st & tx_mk_q));

  assert_masked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_act == '0) |-> (irq_o == '0));

  assert_wake_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wake_fall) |-> wake_req_o);
endmodule

// File: tb/test_can_irq_agg.sv
module test_can_irq_agg;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] tx_done_i = '0, rx_done_i = '0;
  logic        err_bus_i = 1'b0, err_passive_i = 1'b0, err_busoff_i = 1'b0;
  logic        wake_pin_i = 1'b1;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [2:0]  irq_o;
  logic        wake_req_o;
  int n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  can_irq_agg i_can_irq_agg (.*);

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    tick();
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd_chk(input string r, input logic [2:0] a, input logic [31:0] e);
    reg_addr_i = a;
    #1;
    chk(r, reg_rdata_o, e);
  endtask

  task automatic drive_ev(input int cls, input int idx);
    if (cls == 0) tx_done_i[idx] = 1'b1;
    else if (cls == 1) rx_done_i[idx] = 1'b1;
    else {err_busoff_i, err_passive_i, err_bus_i} = 3'(1 << idx);
  endtask

  task automatic clr_ev();
    tx_done_i = '0; rx_done_i = '0;
    {err_busoff_i, err_passive_i, err_bus_i} = '0;
  endtask

  function automatic logic [2:0] st_addr(input int cls);
    return (cls == 0) ? 3'd0 : (cls == 1) ? 3'd1 : 3'd4;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog all act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    #12 rst_ni = 1'b1;
    tick();
    // R1 reset state
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 wake", 32'(wake_req_o), 0);
    for (int a = 0; a < 8; a++) rd_chk("R1 word", 3'(a), 0);

    // R5 mask read/write
    wr(3'd2, 32'h0000_A5A5); rd_chk("R5 txmask", 3'd2, 32'h0000_A5A5);
    wr(3'd3, 32'hFFFF_FFFF); rd_chk("R5 rxmask", 3'd3, 32'h0000_FFFF);
    wr(3'd5, 32'hFFFF_FFFF); rd_chk("R5 ermask", 3'd5, 32'h7);
    wr(3'd2, 32'h0000_FFFF);

    // R2 R3 R4 R6 R7 R8 sweep over both routings and every source
    for (int m = 0; m < 2; m++) begin
      wr(3'd6, 32'(m));
      rd_chk("R8 ctrl", 3'd6, 32'(m));
      for (int cls = 0; cls < 3; cls++) begin
        for (int i = 0; i < ((cls == 2) ? 3 : 16); i++) begin
          drive_ev(cls, i);
          tick();
          clr_ev();
          chk(m ? "R8 split pulse" : "R7 merged pulse", 32'(irq_o),
              m ? 32'(1 << cls) : 32'h7);
          tick();
          chk("R6 pulse ends", 32'(irq_o), 0);
          rd_chk(cls == 2 ? "R3 err status" : "R2 slot status", st_addr(cls), 32'(1 << i));
          wr(st_addr(cls), 32'(1 << i));
          rd_chk("R4 w1c", st_addr(cls), 0);
        end
      end
    end

    // R9 no retrigger while pending (split routing)
    drive_ev(0, 3); tick(); clr_ev();
    chk("R9 first", 32'(irq_o), 32'h1);
    tick();
    drive_ev(0, 5); tick(); clr_ev();
    chk("R9 suppressed", 32'(irq_o), 0);
    drive_ev(1, 0); tick(); clr_ev();
    chk("R8 rx independent", 32'(irq_o), 32'h2);
    wr(3'd1, 32'h1);
    rd_chk("R9 both pending", 3'd0, 32'h28);
    wr(3'd0, 32'h8);
    chk("R9 partial clear", 32'(irq_o), 0);
    rd_chk("R4 partial clear", 3'd0, 32'h20);
    wr(3'd0, 32'h20);
    chk("R9 idle", 32'(irq_o), 0);
    drive_ev(0, 1); tick(); clr_ev();
    chk("R9 rearmed", 32'(irq_o), 32'h1);
    wr(3'd0, 32'h2);

    // R5 masked source, late enable
    wr(3'd2, 32'h0);
    drive_ev(0, 2); tick(); clr_ev();
    chk("R5 masked", 32'(irq_o), 0);
    tick();
    rd_chk("R5 status kept", 3'd0, 32'h4);
    wr(3'd2, 32'h4);
    chk("R5 late enable", 32'(irq_o), 32'h1);
    tick();
    chk("R6 late enable ends", 32'(irq_o), 0);
    wr(3'd0, 32'h4);
    wr(3'd2, 32'hFFFF);

    // R4 clear and event collide
    drive_ev(0, 7); tick(); clr_ev(); tick();
    drive_ev(0, 4);
    wr(3'd0, 32'h90);
    clr_ev();
    rd_chk("R4 event wins", 3'd0, 32'h10);
    wr(3'd0, 32'h10);
    rd_chk("R4 cleared", 3'd0, 0);

    // R10 wake-up edge
    wake_pin_i = 1'b0;
    tick(); tick();
    chk("R10 not yet", 32'(wake_req_o), 0);
    tick();
    chk("R10 set", 32'(wake_req_o), 1);
    rd_chk("R10 word", 3'd7, 1);
    wr(3'd7, 32'h1);
    chk("R4 wake clear", 32'(wake_req_o), 0);
    wake_pin_i = 1'b1;
    repeat (5) tick();
    chk("R10 rise ignored", 32'(wake_req_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule